// File: doc/BRIEF.md
# Multi-speed I2C SCL phase timer

This block paces the clock line of an I2C master. It holds one high-time and one low-time count for each of three speed classes: standard, fast, and a shared class that serves both fast-plus and high speed. A two-bit speed field picks which class is live. A separate hold count sets how many clocks after SCL is pulled low the data line may move. All counts come out of reset already computed from the clock frequency given as a parameter.

While `run` is high, the block emits single-cycle strobes for the bit engine. The engine pulls SCL low, lets data change, and releases SCL. After a release, the block counts the high phase only once it sees the line actually high, so a slave that stretches the clock delays the next bit. Configuration arrives on a small write port. Writes of zero to a count are dropped. Count writes land in the pair of whichever speed class is selected at the time, so the speed has to be chosen first.

Top module: `i2c_scl_timer`

## Requirements
- R1: After reset, with `run` low, no strobe is produced and the selected speed is fast (code 2).
- R2: Reset counts equal CLK_MHZ × t / 1000, truncated. The values of t, in ns, are: standard high 4000, low 4700; fast high 600, low 1300; high-speed high 60, low 160; hold 300.
- R3: A write to address 0 takes bits [2:1] of the data as the speed code: 1 standard, 2 fast, 3 high speed (also used for fast-plus). A code of 0 leaves the speed unchanged.
- R4: A write to address 1 (high count) or address 2 (low count) updates only the pair of the speed selected when the write occurs. The other pairs keep their values.
- R5: A write of zero to address 1, 2 or 3 (hold count) leaves that count unchanged.
- R6: With `run` high in idle, `scl_drive_low_o` pulses in the next cycle. `scl_release_o` pulses exactly L cycles after it, where L is the active low count (L ≥ 2).
- R7: After a release, the high phase begins at the first clock edge that samples `scl_in` high. If `run` is still high, the next `scl_drive_low_o` pulses exactly H cycles after that edge, where H is the active high count. While `scl_in` stays low, no new pulse occurs.
- R8: `sda_change_o` pulses D cycles after each `scl_drive_low_o`. D is the hold count clamped to the range 1 to L−1.
- R9: At most one of the three strobes is high in any cycle.
- R10: If `run` is low when a high phase ends, the block returns to idle and emits no further strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | 0 control, 1 high count, 2 low count, 3 hold count |
| cfg_wdata | input | CNT_W | Write data |
| run | input | 1 | Bit engine requests clock cycles |
| scl_in | input | 1 | Sampled SCL line level |
| scl_drive_low_o | output | 1 | Strobe: pull SCL low |
| scl_release_o | output | 1 | Strobe: release SCL |
| sda_change_o | output | 1 | Strobe: SDA may change |

## Verification
A corrupted count or a wrong pair select shows up as a strobe that lands too early or too late. The error is visible within the first low or high phase after the fault, so the bench timestamps every strobe to the exact cycle. A stuck phase state shows either as strobes during a stretched clock or in idle, or as a missing release. The missing release shows as an unmatched expected event once the burst window closes. A bad hold clamp places the data strobe on or after the release, which breaks both the order of events and the one-strobe rule.

// File: rtl/i2c_sclt_pkg.sv
package i2c_sclt_pkg;

    localparam int NUM_PAIRS = 3;
    localparam int SPEED_LSB = 1;
    localparam int unsigned HOLD_NS = 300;

    typedef enum logic [1:0] {
        SPD_NONE = 2'd0,
        SPD_STD  = 2'd1,
        SPD_FAST = 2'd2,
        SPD_HIGH = 2'd3
    } speed_e;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_HIGH = 2'd1;
    localparam logic [1:0] REG_LOW  = 2'd2;
    localparam logic [1:0] REG_HOLD = 2'd3;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOW,
        PH_WAIT,
        PH_HIGH
    } phase_e;

    // pair index 0 standard, 1 fast, 2 high speed / fast-plus
    function automatic int unsigned min_high_ns(int idx);
        case (idx)
            0:       return 4000;
            1:       return 600;
            default: return 60;
        endcase
    endfunction

    function automatic int unsigned min_low_ns(int idx);
        case (idx)
            0:       return 4700;
            1:       return 1300;
            default: return 160;
        endcase
    endfunction

    function automatic int unsigned ns_to_clk(int unsigned mhz, int unsigned ns);
        return (mhz * ns) / 1000;
    endfunction

endpackage

// File: rtl/i2c_sclt_regs.sv
module i2c_sclt_regs
    import i2c_sclt_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int CLK_MHZ = 250
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic [CNT_W-1:0] wdata,
    output logic [1:0]       speed_o,
    output logic [CNT_W-1:0] high_o,
    output logic [CNT_W-1:0] low_o,
    output logic [CNT_W-1:0] hold_o
);

    typedef struct packed {
        logic [1:0]                      speed;
        logic [NUM_PAIRS-1:0][CNT_W-1:0] high;
        logic [NUM_PAIRS-1:0][CNT_W-1:0] low;
        logic [CNT_W-1:0]                hold;
    } cfg_t;

    function automatic cfg_t reset_cfg();
        cfg_t c;
        c.speed = SPD_FAST;
        for (int i = 0; i < NUM_PAIRS; i++) begin
            c.high[i] = CNT_W'(ns_to_clk(CLK_MHZ, min_high_ns(i)));
            c.low[i]  = CNT_W'(ns_to_clk(CLK_MHZ, min_low_ns(i)));
        end
        c.hold = CNT_W'(ns_to_clk(CLK_MHZ, HOLD_NS));
        return c;
    endfunction

    localparam cfg_t CFG_RST = reset_cfg();

    cfg_t cfg_d, cfg_q;
    logic [NUM_PAIRS-1:0] pair_hit;
    logic [1:0]           new_speed;
    logic                 data_nz;

    generate
        for (genvar gi = 0; gi < NUM_PAIRS; gi++) begin : g_pair
            assign pair_hit[gi] = (cfg_q.speed == 2'(gi + 1));
        end
    endgenerate

    assign new_speed = wdata[SPEED_LSB +: 2];
    assign data_nz   = (wdata != '0);

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            case (addr)
                REG_CTRL: begin
                    if (new_speed != SPD_NONE) begin
                        cfg_d.speed = new_speed;
                    end
                end
                REG_HIGH: begin
                    for (int i = 0; i < NUM_PAIRS; i++) begin
                        if (pair_hit[i] && data_nz) begin
                            cfg_d.high[i] = wdata;
                        end
                    end
                end
                REG_LOW: begin
                    for (int i = 0; i < NUM_PAIRS; i++) begin
                        if (pair_hit[i] && data_nz) begin
                            cfg_d.low[i] = wdata;
                        end
                    end
                end
                default: begin
                    if (data_nz) begin
                        cfg_d.hold = wdata;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RST;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        high_o = '0;
        low_o  = '0;
        for (int i = 0; i < NUM_PAIRS; i++) begin
            if (pair_hit[i]) begin
                high_o = cfg_q.high[i];
                low_o  = cfg_q.low[i];
            end
        end
    end

    assign speed_o = cfg_q.speed;
    assign hold_o  = cfg_q.hold;

endmodule

// File: rtl/i2c_sclt_hold_clamp.sv
module i2c_sclt_hold_clamp #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] hold_i,
    input  logic [CNT_W-1:0] low_i,
    output logic [CNT_W-1:0] hold_eff_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_comb begin
        if (low_i <= ONE + ONE) begin
            hold_eff_o = ONE;
        end else if (hold_i >= low_i) begin
            hold_eff_o = low_i - ONE;
        end else if (hold_i == '0) begin
            hold_eff_o = ONE;
        end else begin
            hold_eff_o = hold_i;
        end
    end

endmodule

// File: rtl/i2c_sclt_phase.sv
module i2c_sclt_phase
    import i2c_sclt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             scl_in,
    input  logic [CNT_W-1:0] high_cnt,
    input  logic [CNT_W-1:0] low_cnt,
    input  logic [CNT_W-1:0] hold_eff,
    output logic             drive_low_o,
    output logic             release_o,
    output logic             sda_change_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic             drv;
        logic             rel;
        logic             sda;
    } st_t;

    st_t st_d, st_q;
    logic [CNT_W-1:0] cnt_inc;

    assign cnt_inc = st_q.cnt + ONE;

    always_comb begin
        st_d     = st_q;
        st_d.drv = 1'b0;
        st_d.rel = 1'b0;
        st_d.sda = 1'b0;
        case (st_q.ph)
            PH_IDLE: begin
                if (run) begin
                    st_d.ph  = PH_LOW;
                    st_d.cnt = '0;
                    st_d.drv = 1'b1;
                end
            end
            PH_LOW: begin
                st_d.cnt = cnt_inc;
                if (cnt_inc == hold_eff) begin
                    st_d.sda = 1'b1;
                end
                if (cnt_inc >= low_cnt) begin
                    st_d.ph  = PH_WAIT;
                    st_d.rel = 1'b1;
                end
            end
            PH_WAIT: begin
                if (scl_in) begin
                    st_d.ph  = PH_HIGH;
                    st_d.cnt = '0;
                end
            end
            default: begin
                st_d.cnt = cnt_inc;
                if (cnt_inc >= high_cnt) begin
                    st_d.cnt = '0;
                    if (run) begin
                        st_d.ph  = PH_LOW;
                        st_d.drv = 1'b1;
                    end else begin
                        st_d.ph = PH_IDLE;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, cnt: '0, drv: 1'b0, rel: 1'b0, sda: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign drive_low_o  = st_q.drv;
    assign release_o    = st_q.rel;
    assign sda_change_o = st_q.sda;

endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer #(
    parameter int CNT_W   = 16,
    parameter int CLK_MHZ = 250
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [CNT_W-1:0] cfg_wdata,
    input  logic             run,
    input  logic             scl_in,
    output logic             scl_drive_low_o,
    output logic             scl_release_o,
    output logic             sda_change_o
);

    logic [1:0]       speed;
    logic [CNT_W-1:0] act_high;
    logic [CNT_W-1:0] act_low;
    logic [CNT_W-1:0] act_hold;
    logic [CNT_W-1:0] hold_eff;

    i2c_sclt_regs #(
        .CNT_W  (CNT_W),
        .CLK_MHZ(CLK_MHZ)
    ) regs_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .speed_o(speed),
        .high_o (act_high),
        .low_o  (act_low),
        .hold_o (act_hold)
    );

    i2c_sclt_hold_clamp #(
        .CNT_W(CNT_W)
    ) clamp_i (
        .hold_i    (act_hold),
        .low_i     (act_low),
        .hold_eff_o(hold_eff)
    );

    i2c_sclt_phase #(
        .CNT_W(CNT_W)
    ) phase_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .scl_in      (scl_in),
        .high_cnt    (act_high),
        .low_cnt     (act_low),
        .hold_eff    (hold_eff),
        .drive_low_o (scl_drive_low_o),
        .release_o   (scl_release_o),
        .sda_change_o(sda_change_o)
    );

endmodule

// File: rtl/i2c_sclt_chk.sv
module i2c_sclt_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             drive_low,
    input logic             rel_s,
    input logic             sda_chg,
    input logic             scl_in,
    input logic             cfg_we,
    input logic [1:0]       cfg_addr,
    input logic [CNT_W-1:0] cfg_wdata,
    input logic [CNT_W-1:0] act_high,
    input logic [CNT_W-1:0] act_low,
    input logic [CNT_W-1:0] act_hold,
    input logic [1:0]       speed
);

    logic in_low_q;
    logic wait_q;
    logic wait_now;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_low_q <= 1'b0;
            wait_q   <= 1'b0;
        end else begin
            if (drive_low) begin
                in_low_q <= 1'b1;
            end else if (rel_s) begin
                in_low_q <= 1'b0;
            end
            if (rel_s) begin
                wait_q <= 1'b1;
            end else if (scl_in) begin
                wait_q <= 1'b0;
            end
        end
    end

    assign wait_now = rel_s || wait_q;

    assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({drive_low, rel_s, sda_chg}));

    assert_sda_inside_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sda_chg |-> in_low_q);

    assert_release_after_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rel_s |-> in_low_q);

    assert_stretch_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_now && !scl_in) |=> !drive_low);

    assert_zero_high_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == 2'd1 && cfg_wdata == '0) |=> $stable(act_high));

    assert_zero_low_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == 2'd2 && cfg_wdata == '0) |=> $stable(act_low));

    assert_zero_hold_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == 2'd3 && cfg_wdata == '0) |=> $stable(act_hold));

    assert_speed_zero_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == 2'd0 && cfg_wdata[2:1] == 2'd0) |=> $stable(speed));

endmodule

bind i2c_scl_timer i2c_sclt_chk #(.CNT_W(CNT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .drive_low(scl_drive_low_o),
    .rel_s    (scl_release_o),
    .sda_chg  (sda_change_o),
    .scl_in   (scl_in),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .act_high (act_high),
    .act_low  (act_low),
    .act_hold (act_hold),
    .speed    (speed)
);

// File: tb/i2c_scl_timer_tb_top.sv
module i2c_scl_timer_tb_top;

    localparam int CW  = 16;
    localparam int MHZ = 250;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_addr = 2'd0;
    logic [CW-1:0] cfg_wdata = '0;
    logic          run = 1'b0;
    logic          scl_in = 1'b1;
    logic          drv, rel, sda;

    always #2 clk = ~clk;

    i2c_scl_timer #(.CNT_W(CW), .CLK_MHZ(MHZ)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_we         (cfg_we),
        .cfg_addr       (cfg_addr),
        .cfg_wdata      (cfg_wdata),
        .run            (run),
        .scl_in         (scl_in),
        .scl_drive_low_o(drv),
        .scl_release_o  (rel),
        .sda_change_o   (sda)
    );

    typedef struct {
        int    kind;   // 0 drive low, 1 release, 2 sda change
        int    at;
        string req;
    } ev_t;

    ev_t exp_q[$];
    int  cyc = 0;
    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    // independent model of the configuration (R2, R3, R4, R5)
    int m_speed;
    int m_hi[3];
    int m_lo[3];
    int m_hold;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, string what, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // monitor: pops expected strobes and compares kind and cycle
    logic [2:0] stb;
    ev_t        cur;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            stb = {sda, rel, drv};
            if (stb[0] + stb[1] + stb[2] > 1) begin
                check(1'b0, "R9", "strobes in one cycle", int'(stb), 0);
            end
            for (int k = 0; k < 3; k++) begin
                if (stb[k]) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R10", "unexpected strobe kind", k, -1);
                    end else begin
                        cur = exp_q.pop_front();
                        check(cur.kind == k && cur.at == cyc, cur.req,
                              "strobe kind*100000+cycle",
                              k * 100000 + cyc, cur.kind * 100000 + cur.at);
                    end
                end
            end
        end
    end

    task automatic wait_cyc(int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic cfg(int a, int v);
        cfg_we    = 1'b1;
        cfg_addr  = 2'(a);
        cfg_wdata = CW'(v);
        @(negedge clk);
        cfg_we = 1'b0;
        case (a)
            0: if (((v >> 1) & 3) != 0) m_speed = (v >> 1) & 3;
            1: if (v != 0) m_hi[m_speed-1] = v;
            2: if (v != 0) m_lo[m_speed-1] = v;
            default: if (v != 0) m_hold = v;
        endcase
        @(negedge clk);
    endtask

    // driver: pushes expected strobes, then drives run and the SCL line
    task automatic burst(int nbits, int stretch, string req);
        int lo, hi, he, start, s0;
        lo = m_lo[m_speed-1];
        hi = m_hi[m_speed-1];
        he = m_hold;
        if (he >= lo) he = lo - 1;
        if (he < 1) he = 1;
        start = cyc + 1;
        s0 = start;
        for (int b = 0; b < nbits; b++) begin
            exp_q.push_back('{0, s0, req});
            exp_q.push_back('{2, s0 + he, req});
            exp_q.push_back('{1, s0 + lo, req});
            s0 = s0 + lo + stretch + 1 + hi;
        end
        run = 1'b1;
        for (int b = 0; b < nbits; b++) begin
            wait_cyc(start);
            scl_in = 1'b0;
            wait_cyc(start + lo);
            if (b == nbits - 1) run = 1'b0;
            wait_cyc(start + lo + stretch);
            scl_in = 1'b1;
            start = start + lo + stretch + 1 + hi;
        end
        wait_cyc(start + 6);
        check(exp_q.size() == 0, "R10", "expected strobes left after burst", exp_q.size(), 0);
    endtask

    initial begin
        m_speed = 2;
        m_hi[0] = MHZ * 4000 / 1000; m_lo[0] = MHZ * 4700 / 1000;
        m_hi[1] = MHZ * 600 / 1000;  m_lo[1] = MHZ * 1300 / 1000;
        m_hi[2] = MHZ * 60 / 1000;   m_lo[2] = MHZ * 160 / 1000;
        m_hold  = MHZ * 300 / 1000;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: quiet after reset with run low
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check({drv, rel, sda} == 3'b000, "R1", "strobes after reset", int'({drv, rel, sda}), 0);
        end

        // R1 R2 R6 R8: fast defaults (speed 2) from reset
        burst(2, 0, "R2");
        // R3: standard speed
        cfg(0, 1 << 1);
        burst(1, 0, "R3");
        // R3 R7 R8: high speed defaults, hold clamped, stretched clock
        cfg(0, 3 << 1);
        burst(3, 5, "R7");
        // R4: program high-speed pair, fast pair stays at defaults
        cfg(1, 8);
        cfg(2, 12);
        cfg(0, 2 << 1);
        burst(1, 0, "R4");
        cfg(0, 3 << 1);
        burst(2, 2, "R4");
        // R5: zero count writes ignored
        cfg(1, 0);
        cfg(2, 0);
        burst(1, 0, "R5");
        // R3: zero speed code ignored (also with bit 0 set)
        cfg(0, 0);
        cfg(0, 1);
        burst(1, 0, "R3");
        // R8: short hold, then zero hold write ignored (R5)
        cfg(3, 4);
        burst(2, 3, "R8");
        cfg(3, 0);
        burst(1, 0, "R5");
        // R6: longer low count on the high-speed pair
        cfg(2, 30);
        burst(2, 1, "R6");
        // R10: idle with run low
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R10", "idle strobes", exp_q.size(), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run hung actual=%0d expected=%0d", cyc, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule